// File: doc/BRIEF.md
# Reset and Wake-Up Start-Up Sequencer

This block decides when the processor core may run after a reset and after a wake from sleep. While any reset source is active, it holds a state-clearing reset on the core. Once every source has let go, it measures up to two delays before letting the core run:

- A supply time-out. It is counted on a slow, separate watchdog clock and gives the supply time to rise.
- A start-up count. It is counted on the main clock and gives the oscillator time to settle.

The block picks the sequence from the cause:

- **Cold start:** takes the time-out and then the start-up count.
- **Cold start with brown-out detection enabled:** the brown-out monitor's release replaces the time-out, so only the start-up count follows.
- **Enabled-interrupt wake from sleep:** takes only the start-up count plus a short fixed stall. The core is halted but not cleared, and a flag tells it to resume through the interrupt path rather than the reset vector.

The time-out counter lives in the watchdog clock domain. It is started and observed through two-flop synchronisers using a four-phase handshake. A new time-out starts only after the watchdog side has been seen idle.

All pins are plain control and status levels; nothing here streams data, so there is no valid/ready handshake. The configuration pins are expected to be static while a delay is running.

Top module: `pwr_start_seq`

## Requirements
- R1: `por_n` low forces `core_rst`=1, `core_halt`=1 and `resume_irq`=0 at once. A high bit of `rst_req` forces the same values from the first `clk` edge that samples it.
- R2: With `bod_en`=1, `bod_ok`=0 acts as a reset source and no time-out is inserted. `core_rst` falls exactly N+1 `clk` edges after the last source is released, where N is the start-up count.
- R3: `cfg_sut_sel` picks the start-up count N in main-clock cycles: 0→6, 1→16, 2→258, 3→1024, 4→16384, 5/6/7→32768.
- R4: With `bod_en`=0, `bod_ok` is ignored. A time-out of 512 (`cfg_tout_long`=0) or 8192 (`cfg_tout_long`=1) `wdt_clk` cycles is inserted ahead of the start-up count, plus a few cycles of synchroniser latency.
- R5: Running with `sleeping`=1 and `wake_irq`=1 raises `core_halt` at the next edge. `core_halt` stays high for exactly N+4 `clk` cycles, and `core_rst` stays 0 throughout.
- R6: `resume_irq` becomes 1 when an interrupt wake begins and stays 1 until the next reset sequence, which clears it.
- R7: `wake_irq` with `sleeping`=0, or `sleeping`=1 without `wake_irq`, leaves `core_halt` at 0 and `resume_irq` unchanged.
- R8: A reset source seen during the time-out, the start-up count or the wake stall returns the block to hold. The full sequence is then re-timed from the last release.
- R9: A reset source while asleep wins over a wake request in the same cycle: `core_rst`=1 and `resume_irq`=0 at the next edge, and a cold sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| wdt_clk | input | 1 | Slow watchdog clock for the time-out |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_req | input | NUM_SRC | Other reset sources, active high, one per bit |
| bod_en | input | 1 | Brown-out detection enabled |
| bod_ok | input | 1 | Brown-out monitor reports supply good |
| sleeping | input | 1 | Core is in a sleep mode |
| wake_irq | input | 1 | Enabled interrupt requests a wake |
| cfg_tout_long | input | 1 | Time-out length select (0: 512, 1: 8192 watchdog cycles) |
| cfg_sut_sel | input | 3 | Start-up count select |
| core_rst | output | 1 | State-clearing reset to the core |
| core_halt | output | 1 | Core stall; high whenever the core may not run |
| resume_irq | output | 1 | 1: resume via the interrupt path; 0: start at the reset vector |

## Verification
A reset request and an interrupt wake can land in the same cycle while the core sleeps. The bench first completes a wake so that `resume_irq` is 1. It then drives `sleeping`, `wake_irq` and a `rst_req` bit together at one falling edge. The reset must win at the next edge, with `core_rst` high and `resume_irq` cleared, and the cold sequence that follows must have the exact start-up length. A reset arriving in the middle of a wake stall is provoked the same way, and is judged by the same flag clear and the full re-timing.

// File: rtl/pss_pkg.sv
package pss_pkg;

  localparam int unsigned SUT_MAX = 32768;
  localparam int unsigned SUT_CW  = $clog2(SUT_MAX + 1);

  typedef enum logic [2:0] {
    ST_HOLD   = 3'd0,
    ST_TOUT   = 3'd1,
    ST_SUT    = 3'd2,
    ST_RUN    = 3'd3,
    ST_WSUT   = 3'd4,
    ST_WSTALL = 3'd5
  } pss_state_e;

  // Start-up count in main-clock cycles for each select code (R3)
  function automatic logic [SUT_CW-1:0] sut_cycles(input logic [2:0] sel);
    case (sel)
      3'd0:    return SUT_CW'(6);
      3'd1:    return SUT_CW'(16);
      3'd2:    return SUT_CW'(258);
      3'd3:    return SUT_CW'(1024);
      3'd4:    return SUT_CW'(16384);
      default: return SUT_CW'(SUT_MAX);
    endcase
  endfunction

endpackage

// File: rtl/pss_sync2.sv
module pss_sync2 #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= '0;
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];

endmodule

// File: rtl/pss_delay_count.sv
module pss_delay_count #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic          last
);

  logic [CW-1:0] cnt;

  assign last = en && (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!en)  cnt <= '0;
    else if (last) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R3: the running count never passes the selected length
  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt < limit));

endmodule

// File: rtl/pss_tout_timer.sv
module pss_tout_timer #(
  parameter int unsigned SHORT = 512,
  parameter int unsigned LONG  = 8192
) (
  input  logic wdt_clk,
  input  logic rst_n,
  input  logic go,
  input  logic long_sel,
  output logic done,
  output logic active
);

  localparam int unsigned CW = $clog2(LONG + 1);

  logic          go_s;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  pss_sync2 #(.STAGES(2)) u_go_sync (
    .clk   (wdt_clk),
    .rst_n (rst_n),
    .d     (go),
    .q     (go_s)
  );

  assign lim = long_sel ? CW'(LONG) : CW'(SHORT);

  always_ff @(posedge wdt_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      done   <= 1'b0;
      active <= 1'b0;
    end else begin
      active <= go_s | done;
      if (!go_s) begin
        cnt  <= '0;
        done <= 1'b0;
      end else if (!done) begin
        if (cnt == lim - 1'b1) done <= 1'b1;
        else                   cnt  <= cnt + 1'b1;
      end
    end
  end

  // R4: once reached, the time-out stays reported until the request is dropped
  assert_done_sticky_R4: assert property (@(posedge wdt_clk) disable iff (!rst_n)
    (go_s && done) |=> done);

endmodule

// File: rtl/pwr_start_seq.sv
module pwr_start_seq
  import pss_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 3,
  parameter int unsigned TOUT_SHORT = 512,
  parameter int unsigned TOUT_LONG  = 8192,
  parameter int unsigned WAKE_STALL = 4
) (
  input  logic               clk,
  input  logic               wdt_clk,
  input  logic               por_n,
  input  logic [NUM_SRC-1:0] rst_req,
  input  logic               bod_en,
  input  logic               bod_ok,
  input  logic               sleeping,
  input  logic               wake_irq,
  input  logic               cfg_tout_long,
  input  logic [2:0]         cfg_sut_sel,
  output logic               core_rst,
  output logic               core_halt,
  output logic               resume_irq
);

  pss_state_e        state, nxt;
  logic              src_act;
  logic              tout_go;
  logic              w_done, w_act;
  logic              w_done_s, w_act_s;
  logic              cnt_en, cnt_last;
  logic [SUT_CW-1:0] cnt_lim;

  assign src_act = (|rst_req) | (bod_en & ~bod_ok);
  assign tout_go = (state == ST_TOUT);

  pss_tout_timer #(.SHORT(TOUT_SHORT), .LONG(TOUT_LONG)) u_tout (
    .wdt_clk  (wdt_clk),
    .rst_n    (por_n),
    .go       (tout_go),
    .long_sel (cfg_tout_long),
    .done     (w_done),
    .active   (w_act)
  );

  pss_sync2 #(.STAGES(2)) u_done_sync (
    .clk (clk), .rst_n (por_n), .d (w_done), .q (w_done_s)
  );

  pss_sync2 #(.STAGES(2)) u_act_sync (
    .clk (clk), .rst_n (por_n), .d (w_act), .q (w_act_s)
  );

  // One counter serves the start-up count and the wake stall
  assign cnt_en  = (state == ST_SUT) || (state == ST_WSUT) || (state == ST_WSTALL);
  assign cnt_lim = (state == ST_WSTALL) ? SUT_CW'(WAKE_STALL) : sut_cycles(cfg_sut_sel);

  pss_delay_count #(.CW(SUT_CW)) u_cnt (
    .clk   (clk),
    .rst_n (por_n),
    .en    (cnt_en),
    .limit (cnt_lim),
    .last  (cnt_last)
  );

  always_comb begin
    nxt = state;
    if (src_act) begin
      nxt = ST_HOLD;
    end else begin
      unique case (state)
        ST_HOLD:   if (!w_done_s && !w_act_s) nxt = bod_en ? ST_SUT : ST_TOUT;
        ST_TOUT:   if (w_done_s) nxt = ST_SUT;
        ST_SUT:    if (cnt_last) nxt = ST_RUN;
        ST_RUN:    if (sleeping && wake_irq) nxt = ST_WSUT;
        ST_WSUT:   if (cnt_last) nxt = ST_WSTALL;
        ST_WSTALL: if (cnt_last) nxt = ST_RUN;
        default:   nxt = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state      <= ST_HOLD;
      resume_irq <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt == ST_HOLD)                           resume_irq <= 1'b0;
      else if (state == ST_RUN && nxt == ST_WSUT)   resume_irq <= 1'b1;
    end
  end

  assign core_rst  = (state == ST_HOLD) || (state == ST_TOUT) || (state == ST_SUT);
  assign core_halt = (state != ST_RUN);

  // R1: any sampled reset source puts the core into reset at the next edge
  assert_src_resets_R1: assert property (@(posedge clk) disable iff (!por_n)
    src_act |=> (core_rst && core_halt));

  // R2: with brown-out detection on, the time-out is never entered
  assert_skip_tout_R2: assert property (@(posedge clk) disable iff (!por_n)
    (bod_en && state == ST_HOLD) |=> (state != ST_TOUT));

  // R5: an interrupt wake halts the core without clearing it
  assert_wake_halt_R5: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_RUN && sleeping && wake_irq && !src_act) |=> (core_halt && !core_rst));

  // R6: a fresh reset never starts with the interrupt-resume flag set
  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_rst) |-> !resume_irq);

  // R7: no wake without both sleep and an interrupt
  assert_no_spurious_wake_R7: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_RUN && !(sleeping && wake_irq) && !src_act) |=> !core_halt);

  // R8: a source seen in any delay restarts the sequence from hold
  assert_restart_R8: assert property (@(posedge clk) disable iff (!por_n)
    (state != ST_RUN && state != ST_HOLD && src_act) |=> (state == ST_HOLD));

  // R9: reset beats a wake request while asleep
  assert_sleep_reset_R9: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_RUN && sleeping && src_act) |=> (core_rst && !resume_irq));

endmodule

// File: tb/tb_pwr_start_seq.sv
module tb_pwr_start_seq;

  logic       clk = 1'b0;
  logic       wdt_clk = 1'b0;
  logic       por_n = 1'b0;
  logic [2:0] rst_req = 3'b000;
  logic       bod_en = 1'b1;
  logic       bod_ok = 1'b1;
  logic       sleeping = 1'b0;
  logic       wake_irq = 1'b0;
  logic       cfg_tout_long = 1'b0;
  logic [2:0] cfg_sut_sel = 3'd0;
  logic       core_rst, core_halt, resume_irq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  pwr_start_seq dut (
    .clk           (clk),
    .wdt_clk       (wdt_clk),
    .por_n         (por_n),
    .rst_req       (rst_req),
    .bod_en        (bod_en),
    .bod_ok        (bod_ok),
    .sleeping      (sleeping),
    .wake_irq      (wake_irq),
    .cfg_tout_long (cfg_tout_long),
    .cfg_sut_sel   (cfg_sut_sel),
    .core_rst      (core_rst),
    .core_halt     (core_halt),
    .resume_irq    (resume_irq)
  );

  always #4 clk = ~clk;
  initial begin
    #3;
    forever #16 wdt_clk = ~wdt_clk;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung (actual cycles=%0d expected < 190000)", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int exp_sut(input int sel);
    case (sel)
      0: return 6;
      1: return 16;
      2: return 258;
      3: return 1024;
      4: return 16384;
      default: return 32768;
    endcase
  endfunction

  task automatic hold_src(input int n);
    rst_req[0] = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  // Release all sources at the current falling edge, count edges until core_rst drops
  task automatic release_measure(output int n);
    rst_req = 3'b000;
    bod_ok  = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (core_rst && n < 70000);
  endtask

  task automatic wake_measure(output int n, output int rst_hits);
    n = 0;
    rst_hits = 0;
    sleeping = 1'b1;
    wake_irq = 1'b1;
    @(negedge clk);
    while (core_halt && n < 70000) begin
      n++;
      if (core_rst) rst_hits++;
      sleeping = 1'b0;
      wake_irq = 1'b0;
      @(negedge clk);
    end
    sleeping = 1'b0;
    wake_irq = 1'b0;
  endtask

  initial begin
    int n;
    int hits;
    int halts;
    void'($urandom(32'd7741));

    repeat (3) @(negedge clk);
    // R1: power-on state
    chk(core_rst === 1'b1 && core_halt === 1'b1 && resume_irq === 1'b0,
        "R1 power-on outputs", {core_rst, core_halt, resume_irq}, 3'b110);

    // R2: first release with brown-out detection on, select 0
    por_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (core_rst && n < 70000);
    chk(n == 7, "R2 start after power-on", n, 7);

    // R1: a request bit puts the core in reset at the next edge
    rst_req[1] = 1'b1;
    @(negedge clk);
    chk(core_rst === 1'b1 && core_halt === 1'b1, "R1 request asserts reset",
        {core_rst, core_halt}, 2'b11);
    rst_req[1] = 1'b0;

    // R3: every distinct start-up count
    for (int sel = 0; sel < 6; sel++) begin
      cfg_sut_sel = 3'(sel);
      hold_src(24);
      release_measure(n);
      chk(n == exp_sut(sel) + 1, $sformatf("R3 start-up count sel=%0d", sel), n, exp_sut(sel) + 1);
    end

    // R2: brown-out as a source, no time-out
    cfg_sut_sel = 3'd1;
    bod_ok = 1'b0;
    repeat (24) @(negedge clk);
    chk(core_rst === 1'b1, "R2 brown-out holds reset", core_rst, 1);
    release_measure(n);
    chk(n == 17, "R2 brown-out release", n, 17);

    // R4: short time-out, brown-out level ignored
    cfg_sut_sel = 3'd0;
    bod_en = 1'b0;
    hold_src(24);
    rst_req = 3'b000;
    bod_ok = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (core_rst && n < 70000);
    chk(n >= 4 * 512 + 7 && n <= 4 * 512 + 67, "R4 short time-out", n, 4 * 512 + 7);
    bod_ok = 1'b1;

    // R4: long time-out
    cfg_tout_long = 1'b1;
    hold_src(24);
    release_measure(n);
    chk(n >= 4 * 8192 + 7 && n <= 4 * 8192 + 67, "R4 long time-out", n, 4 * 8192 + 7);
    cfg_tout_long = 1'b0;
    hold_src(24);
    bod_en = 1'b1;
    release_measure(n);

    // R5 and R6: interrupt wake
    cfg_sut_sel = 3'd1;
    wake_measure(n, hits);
    chk(n == 20, "R5 wake halt length", n, 20);
    chk(hits == 0, "R5 no reset during wake", hits, 0);
    chk(resume_irq === 1'b1, "R6 resume flag after wake", resume_irq, 1);

    // R7: wake request without sleep, and sleep without request
    halts = 0;
    wake_irq = 1'b1;
    repeat (10) begin @(negedge clk); if (core_halt) halts++; end
    wake_irq = 1'b0;
    sleeping = 1'b1;
    repeat (10) begin @(negedge clk); if (core_halt) halts++; end
    sleeping = 1'b0;
    chk(halts == 0, "R7 halt stays low", halts, 0);
    chk(resume_irq === 1'b1, "R7 flag unchanged", resume_irq, 1);

    // R8: restart inside the start-up count
    cfg_sut_sel = 3'd3;
    hold_src(24);
    rst_req = 3'b000;
    repeat (500) @(negedge clk);
    chk(core_rst === 1'b1, "R8 still counting", core_rst, 1);
    hold_src(24);
    release_measure(n);
    chk(n == 1025, "R8 restart in start-up", n, 1025);

    // R8: restart inside the time-out
    cfg_sut_sel = 3'd0;
    bod_en = 1'b0;
    hold_src(24);
    rst_req = 3'b000;
    repeat (1000) @(negedge clk);
    hold_src(24);
    release_measure(n);
    chk(n >= 4 * 512 + 7 && n <= 4 * 512 + 67, "R8 restart in time-out", n, 4 * 512 + 7);
    hold_src(24);
    bod_en = 1'b1;
    release_measure(n);

    // R8 and R9: reset in the middle of a wake
    cfg_sut_sel = 3'd3;
    sleeping = 1'b1;
    wake_irq = 1'b1;
    @(negedge clk);
    sleeping = 1'b0;
    wake_irq = 1'b0;
    repeat (100) @(negedge clk);
    chk(core_halt === 1'b1 && core_rst === 1'b0, "R5 mid-wake stall",
        {core_halt, core_rst}, 2'b10);
    rst_req[2] = 1'b1;
    @(negedge clk);
    chk(core_rst === 1'b1 && resume_irq === 1'b0, "R8 reset during wake",
        {core_rst, resume_irq}, 2'b10);
    hold_src(24);
    release_measure(n);
    chk(n == 1025, "R8 cold after wake abort", n, 1025);

    // R9: reset while asleep
    cfg_sut_sel = 3'd0;
    wake_measure(n, hits);
    sleeping = 1'b1;
    repeat (5) @(negedge clk);
    rst_req[2] = 1'b1;
    @(negedge clk);
    sleeping = 1'b0;
    chk(core_rst === 1'b1 && resume_irq === 1'b0, "R9 reset while asleep",
        {core_rst, resume_irq}, 2'b10);
    hold_src(24);
    release_measure(n);
    chk(n == 7 && resume_irq === 1'b0, "R9 cold start from sleep", n, 7);

    // R9: reset and wake in the same cycle
    wake_measure(n, hits);
    sleeping = 1'b1;
    wake_irq = 1'b1;
    rst_req[0] = 1'b1;
    @(negedge clk);
    sleeping = 1'b0;
    wake_irq = 1'b0;
    chk(core_rst === 1'b1 && resume_irq === 1'b0, "R9 reset beats wake",
        {core_rst, resume_irq}, 2'b10);
    hold_src(24);
    release_measure(n);
    chk(n == 7, "R9 cold after collision", n, 7);

    // Random mix of cold starts and wakes
    for (int i = 0; i < 16; i++) begin
      int sel;
      sel = int'($urandom % 4);
      cfg_sut_sel = 3'(sel);
      if ($urandom % 2 == 0) begin
        if ($urandom % 2 == 0) rst_req = 3'(1 << ($urandom % 3));
        else bod_ok = 1'b0;
        repeat (24) @(negedge clk);
        release_measure(n);
        chk(n == exp_sut(sel) + 1, "R3 random cold start", n, exp_sut(sel) + 1);
        chk(resume_irq === 1'b0, "R6 random cold flag", resume_irq, 0);
      end else begin
        wake_measure(n, hits);
        chk(n == exp_sut(sel) + 4 && hits == 0, "R5 random wake", n, exp_sut(sel) + 4);
        chk(resume_irq === 1'b1, "R6 random wake flag", resume_irq, 1);
      end
      repeat (3) @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule